// File: doc/BRIEF.md
# Rotating Register Loop Branch Unit

This block steers a modulo-scheduled loop. It holds a trip counter, a drain counter and a rotation base. On each pulse of the loop-closing branch it decides whether the branch is taken or falls through. It updates the two counters and, while the pipeline is filling, running or draining, turns the register and predicate windows by one position.

The rotating general-register window starts at register 32. The rotating stage-predicate window starts at predicate 16. Both are `ROT_N` entries wide and share one base. A logical index inside a window is mapped to its physical slot through the base. An index outside a window passes through unchanged. The block also keeps the rotating stage-predicate bits and returns the value that a logical predicate index currently names. Each rotation writes the new stage bit into logical predicate 16, so a stage enabled in one iteration moves on to predicates 17 and 18 in the iterations that follow.

Software starts a loop by loading both counters in one strobe. The strobe also resets the base and primes the stage predicates for the first iteration. Instruction fetch and register storage live outside this block.

Top module: `rot_loop_branch_unit`

## Requirements
- R1: After reset both counters and the base are zero and every rotating predicate reads 0, so logical and physical indices are equal.
- R2: A load strobe writes the trip and drain counters, sets the base to 0, makes logical predicate 16 read 1 and makes logical predicates 17 to 16+ROT_N-1 read 0 from the next cycle.
- R3: When load and branch are high in the same cycle, the load wins: taken and fall-through both stay low and the branch changes no state.
- R4: A branch with a nonzero trip counter is taken. It decrements the trip counter, keeps the drain counter, rotates by one and writes 1 into logical predicate 16.
- R5: A branch with a zero trip counter and a drain counter above 1 is taken. It decrements the drain counter, rotates by one and writes 0 into logical predicate 16.
- R6: A branch with a zero trip counter and a drain counter of exactly 1 falls through. It brings the drain counter to 0, rotates by one and writes 0 into logical predicate 16.
- R7: A branch with both counters at zero falls through and changes neither the counters, the base nor the predicates.
- R8: A general register L with 32 <= L < 32+ROT_N maps to 32 + ((L-32+base) mod ROT_N). Each rotation lowers the base by one, and the base wraps from 0 to ROT_N-1.
- R9: A general register index outside the rotating window maps to itself.
- R10: A predicate index P with 16 <= P < 16+ROT_N maps to 16 + ((P-16+base) mod ROT_N). A predicate index outside that window maps to itself and reads 0.
- R11: A stage bit written into logical predicate 16 by one rotation reads from logical predicate 17 after the next rotation and from logical predicate 18 after the one after that.
- R12: Taken and fall-through are combinational in the cycle the branch is high. Both are low when no branch is present, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_i | input | 1 | Load strobe for the loop counters |
| ld_trip_i | input | CNT_W | Trip count to load |
| ld_drain_i | input | CNT_W | Drain count to load |
| br_i | input | 1 | Loop branch pulse |
| taken_o | output | 1 | Branch taken this cycle |
| fallthru_o | output | 1 | Branch falls through this cycle |
| gr_log_i | input | GR_IDX_W | Logical general-register index |
| gr_phys_o | output | GR_IDX_W | Physical general-register index |
| pr_log_i | input | PR_IDX_W | Logical predicate index |
| pr_phys_o | output | PR_IDX_W | Physical predicate index |
| pr_val_o | output | 1 | Value of the logical predicate |

## Verification
The checker checks on every cycle the following: the two branch outcomes never rise together, the load beats a branch, the counters move by the rule for the case that was active, the base steps down with wrap on each rotation and stays put on an exhausted exit, and registers below the window map to themselves. Only the bench's scenarios can show how stage bits travel through predicates 16, 17 and 18 across iterations, how a full prologue, kernel and epilogue sequence behaves, and how the mapping looks after the base has wrapped. The bench gets these from a queue model of the logical predicate window and a free-running integer base.

// File: rtl/rlb_pkg.sv
package rlb_pkg;
  typedef enum logic [2:0] {
    BK_NONE,
    BK_LOAD,
    BK_KERNEL,
    BK_DRAIN,
    BK_LAST,
    BK_EXIT
  } br_kind_e;
endpackage

// File: rtl/rlb_branch_ctrl.sv
module rlb_branch_ctrl
  import rlb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ROT_N  = 8,
  parameter int BASE_W = $clog2(ROT_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [CNT_W-1:0]  ld_trip_i,
  input  logic [CNT_W-1:0]  ld_drain_i,
  input  logic              br_i,
  output logic              taken_o,
  output logic              fallthru_o,
  output logic              rot_o,
  output logic              stage_o,
  output logic [BASE_W-1:0] base_o,
  output logic [BASE_W-1:0] base_nxt_o,
  output logic [CNT_W-1:0]  trip_o,
  output logic [CNT_W-1:0]  drain_o
);
  localparam logic [BASE_W-1:0] BASE_TOP = BASE_W'(ROT_N - 1);

  logic [CNT_W-1:0]  trip_q, drain_q;
  logic [BASE_W-1:0] base_q;
  br_kind_e          kind;

  always_comb begin
    if (ld_i)                      kind = BK_LOAD;
    else if (!br_i)                kind = BK_NONE;
    else if (trip_q != '0)         kind = BK_KERNEL;
    else if (drain_q > CNT_W'(1))  kind = BK_DRAIN;
    else if (drain_q == CNT_W'(1)) kind = BK_LAST;
    else                           kind = BK_EXIT;
  end

  assign taken_o    = (kind == BK_KERNEL) || (kind == BK_DRAIN);
  assign fallthru_o = (kind == BK_LAST) || (kind == BK_EXIT);
  assign rot_o      = (kind == BK_KERNEL) || (kind == BK_DRAIN) || (kind == BK_LAST);
  assign stage_o    = (kind == BK_KERNEL);
  assign base_nxt_o = (base_q == '0) ? BASE_TOP : base_q - BASE_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_q  <= '0;
      drain_q <= '0;
      base_q  <= '0;
    end else begin
      unique case (kind)
        BK_LOAD: begin
          trip_q  <= ld_trip_i;
          drain_q <= ld_drain_i;
          base_q  <= '0;
        end
        BK_KERNEL: begin
          trip_q <= trip_q - CNT_W'(1);
          base_q <= base_nxt_o;
        end
        BK_DRAIN, BK_LAST: begin
          drain_q <= drain_q - CNT_W'(1);
          base_q  <= base_nxt_o;
        end
        default: ;
      endcase
    end
  end

  assign base_o  = base_q;
  assign trip_o  = trip_q;
  assign drain_o = drain_q;
endmodule

// File: rtl/rlb_rot_map.sv
module rlb_rot_map #(
  parameter int IDX_W  = 7,
  parameter int WIN_LO = 32,
  parameter int WIN_N  = 8,
  parameter int BASE_W = $clog2(WIN_N)
) (
  input  logic [IDX_W-1:0]  log_i,
  input  logic [BASE_W-1:0] base_i,
  output logic [IDX_W-1:0]  phys_o,
  output logic              in_win_o,
  output logic [BASE_W-1:0] slot_o
);
  localparam int OFF_W = BASE_W + 1;
  localparam logic [IDX_W-1:0] LO = IDX_W'(WIN_LO);
  localparam logic [IDX_W-1:0] HI = IDX_W'(WIN_LO + WIN_N);

  logic [IDX_W-1:0] rel;
  logic [OFF_W-1:0] sum, wrapped;

  assign in_win_o = (log_i >= LO) && (log_i < HI);
  assign rel      = log_i - LO;
  assign sum      = {1'b0, rel[BASE_W-1:0]} + {1'b0, base_i};
  assign wrapped  = (sum >= OFF_W'(WIN_N)) ? sum - OFF_W'(WIN_N) : sum;
  assign slot_o   = wrapped[BASE_W-1:0];
  assign phys_o   = in_win_o ? LO + IDX_W'(slot_o) : log_i;
endmodule

// File: rtl/rlb_pred_bank.sv
module rlb_pred_bank #(
  parameter int ROT_N  = 8,
  parameter int BASE_W = $clog2(ROT_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prime_i,
  input  logic              rot_i,
  input  logic [BASE_W-1:0] wr_slot_i,
  input  logic              stage_i,
  input  logic              rd_en_i,
  input  logic [BASE_W-1:0] rd_slot_i,
  output logic              val_o
);
  logic [ROT_N-1:0] bits_q;

  for (genvar g = 0; g < ROT_N; g++) begin : g_bit
    // priming happens with base 0, so logical p16 sits in slot 0
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      bits_q[g] <= 1'b0;
      else if (prime_i)                                 bits_q[g] <= (g == 0);
      else if (rot_i && (wr_slot_i == BASE_W'(g)))      bits_q[g] <= stage_i;
    end
  end

  assign val_o = rd_en_i && bits_q[rd_slot_i];
endmodule

// File: rtl/rot_loop_branch_unit.sv
module rot_loop_branch_unit #(
  parameter int CNT_W     = 16,
  parameter int ROT_N     = 8,
  parameter int GR_IDX_W  = 7,
  parameter int GR_ROT_LO = 32,
  parameter int PR_IDX_W  = 6,
  parameter int PR_ROT_LO = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_i,
  input  logic [CNT_W-1:0]    ld_trip_i,
  input  logic [CNT_W-1:0]    ld_drain_i,
  input  logic                br_i,
  output logic                taken_o,
  output logic                fallthru_o,
  input  logic [GR_IDX_W-1:0] gr_log_i,
  output logic [GR_IDX_W-1:0] gr_phys_o,
  input  logic [PR_IDX_W-1:0] pr_log_i,
  output logic [PR_IDX_W-1:0] pr_phys_o,
  output logic                pr_val_o
);
  localparam int BASE_W = $clog2(ROT_N);

  logic              rot_w, stage_w, pr_in_win;
  logic [BASE_W-1:0] base_w, base_nxt_w, pr_slot, gr_slot_unused;
  logic [CNT_W-1:0]  trip_w, drain_w;
  logic              gr_in_win_unused;

  rlb_branch_ctrl #(.CNT_W(CNT_W), .ROT_N(ROT_N), .BASE_W(BASE_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_i       (ld_i),
    .ld_trip_i  (ld_trip_i),
    .ld_drain_i (ld_drain_i),
    .br_i       (br_i),
    .taken_o    (taken_o),
    .fallthru_o (fallthru_o),
    .rot_o      (rot_w),
    .stage_o    (stage_w),
    .base_o     (base_w),
    .base_nxt_o (base_nxt_w),
    .trip_o     (trip_w),
    .drain_o    (drain_w)
  );

  rlb_rot_map #(.IDX_W(GR_IDX_W), .WIN_LO(GR_ROT_LO), .WIN_N(ROT_N), .BASE_W(BASE_W)) u_gr_map (
    .log_i    (gr_log_i),
    .base_i   (base_w),
    .phys_o   (gr_phys_o),
    .in_win_o (gr_in_win_unused),
    .slot_o   (gr_slot_unused)
  );

  rlb_rot_map #(.IDX_W(PR_IDX_W), .WIN_LO(PR_ROT_LO), .WIN_N(ROT_N), .BASE_W(BASE_W)) u_pr_map (
    .log_i    (pr_log_i),
    .base_i   (base_w),
    .phys_o   (pr_phys_o),
    .in_win_o (pr_in_win),
    .slot_o   (pr_slot)
  );

  // new stage bit lands in the slot logical p16 names after this rotation
  rlb_pred_bank #(.ROT_N(ROT_N), .BASE_W(BASE_W)) u_pred (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prime_i   (ld_i),
    .rot_i     (rot_w),
    .wr_slot_i (base_nxt_w),
    .stage_i   (stage_w),
    .rd_en_i   (pr_in_win),
    .rd_slot_i (pr_slot),
    .val_o     (pr_val_o)
  );
endmodule

// File: rtl/rlb_checker.sv
module rlb_checker #(
  parameter int CNT_W     = 16,
  parameter int ROT_N     = 8,
  parameter int GR_IDX_W  = 7,
  parameter int GR_ROT_LO = 32,
  parameter int BASE_W    = $clog2(ROT_N)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ld_i,
  input logic [CNT_W-1:0]    ld_trip_i,
  input logic [CNT_W-1:0]    ld_drain_i,
  input logic                br_i,
  input logic                taken_i,
  input logic                fallthru_i,
  input logic [GR_IDX_W-1:0] gr_log_i,
  input logic [GR_IDX_W-1:0] gr_phys_i,
  input logic [CNT_W-1:0]    trip_i,
  input logic [CNT_W-1:0]    drain_i,
  input logic [BASE_W-1:0]   base_i
);
  localparam logic [BASE_W-1:0] BASE_TOP = BASE_W'(ROT_N - 1);

  p_one_outcome_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(taken_i && fallthru_i) && ((taken_i || fallthru_i) -> br_i));

  p_load_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |-> !taken_i && !fallthru_i);

  p_load_init_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (base_i == '0) && (trip_i == $past(ld_trip_i)) && (drain_i == $past(ld_drain_i)));

  p_kernel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_i && !ld_i && trip_i != '0) |=>
      (trip_i == $past(trip_i) - CNT_W'(1)) && (drain_i == $past(drain_i)));

  // covers R6 as well: drain reaches 0 from 1
  p_drain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_i && !ld_i && trip_i == '0 && drain_i != '0) |=>
      (drain_i == $past(drain_i) - CNT_W'(1)) && (trip_i == '0));

  p_rotate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_i && !ld_i && (trip_i != '0 || drain_i != '0)) |=>
      base_i == (($past(base_i) == '0) ? BASE_TOP : $past(base_i) - BASE_W'(1)));

  p_exit_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_i && !ld_i && trip_i == '0 && drain_i == '0) |=>
      $stable(base_i) && (trip_i == '0) && (drain_i == '0));

  p_gr_static_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gr_log_i < GR_IDX_W'(GR_ROT_LO)) |-> gr_phys_i == gr_log_i);
endmodule

bind rot_loop_branch_unit rlb_checker #(
  .CNT_W(CNT_W), .ROT_N(ROT_N), .GR_IDX_W(GR_IDX_W), .GR_ROT_LO(GR_ROT_LO)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ld_i       (ld_i),
  .ld_trip_i  (ld_trip_i),
  .ld_drain_i (ld_drain_i),
  .br_i       (br_i),
  .taken_i    (taken_o),
  .fallthru_i (fallthru_o),
  .gr_log_i   (gr_log_i),
  .gr_phys_i  (gr_phys_o),
  .trip_i     (trip_w),
  .drain_i    (drain_w),
  .base_i     (base_w)
);

// File: tb/rot_loop_branch_unit_bench.sv
`timescale 1ns/1ps
module rot_loop_branch_unit_bench;
  localparam int N = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_i = 1'b0;
  logic [15:0] ld_trip_i = '0;
  logic [15:0] ld_drain_i = '0;
  logic        br_i = 1'b0;
  logic        taken_o, fallthru_o, pr_val_o;
  logic [6:0]  gr_log_i = '0;
  logic [6:0]  gr_phys_o;
  logic [5:0]  pr_log_i = '0;
  logic [5:0]  pr_phys_o;

  always #4 clk_i = ~clk_i;

  rot_loop_branch_unit u_rot_loop_branch_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld_i), .ld_trip_i(ld_trip_i),
    .ld_drain_i(ld_drain_i), .br_i(br_i), .taken_o(taken_o), .fallthru_o(fallthru_o),
    .gr_log_i(gr_log_i), .gr_phys_o(gr_phys_o), .pr_log_i(pr_log_i),
    .pr_phys_o(pr_phys_o), .pr_val_o(pr_val_o)
  );

  int n_vec = 0, n_bad = 0;
  int m_trip = 0, m_drain = 0, m_base = 0;
  bit m_pr[$];
  bit done = 0;

  function automatic int md(int x);
    return ((x % N) + N) % N;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rotate(bit s);
    m_base--;
    m_pr.push_front(s);
    void'(m_pr.pop_back());
  endtask

  task automatic step(bit ld, int trip, int drain, bit br, int gr, int pr);
    string rq;
    int et, ef, egr, epr, ev;
    @(negedge clk_i);
    ld_i = ld; ld_trip_i = 16'(trip); ld_drain_i = 16'(drain); br_i = br;
    gr_log_i = 7'(gr); pr_log_i = 6'(pr);
    #1;
    et = 0; ef = 0;
    if (ld)                rq = "R3";
    else if (!br)          rq = "R12";
    else if (m_trip != 0)  begin rq = "R4"; et = 1; end
    else if (m_drain > 1)  begin rq = "R5"; et = 1; end
    else if (m_drain == 1) begin rq = "R6"; ef = 1; end
    else                   begin rq = "R7"; ef = 1; end
    chk(rq, int'(taken_o), et);
    chk(rq, int'(fallthru_o), ef);
    if (gr >= 32 && gr < 32 + N) begin egr = 32 + md(gr - 32 + m_base); chk("R8", int'(gr_phys_o), egr); end
    else chk("R9", int'(gr_phys_o), gr);
    if (pr >= 16 && pr < 16 + N) begin
      epr = 16 + md(pr - 16 + m_base); ev = int'(m_pr[pr - 16]);
      chk("R10", int'(pr_phys_o), epr);
      chk("R11", int'(pr_val_o), ev);
    end else begin
      chk("R10", int'(pr_phys_o), pr);
      chk("R10", int'(pr_val_o), 0);
    end
    @(posedge clk_i);
    if (ld) begin
      m_trip = trip; m_drain = drain; m_base = 0;
      foreach (m_pr[k]) m_pr[k] = 0;
      m_pr[0] = 1;
    end else if (br) begin
      if (m_trip != 0)       begin m_trip--;  rotate(1); end
      else if (m_drain != 0) begin m_drain--; rotate(0); end
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL R12: watchdog expired, actual 0 expected 1 completions");
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) m_pr.push_back(1'b0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1: reset state visible through the mapping and predicates
    @(negedge clk_i); gr_log_i = 7'd35; pr_log_i = 6'd16; #1;
    chk("R1", int'(gr_phys_o), 35);
    chk("R1", int'(pr_val_o), 0);
    chk("R1", int'(pr_phys_o), 16);
    step(0, 0, 0, 1, 33, 17);   // exhausted branch after reset

    // R2: load primes stage predicates, then a full 4/3 loop
    step(1, 4, 3, 0, 32, 16);
    @(negedge clk_i); br_i = 0; ld_i = 0; pr_log_i = 6'd16; #1;
    chk("R2", int'(pr_val_o), 1);
    pr_log_i = 6'd17; #1;
    chk("R2", int'(pr_val_o), 0);
    for (int i = 0; i < 9; i++) step(0, 0, 0, 1, 32 + (i % N), 16 + (i % 3));
    // R11: sweep logical predicates after an epilogue
    for (int p = 14; p < 26; p++) step(0, 0, 0, 0, 30 + p, p);

    // R3: load and branch together
    step(1, 2, 2, 1, 39, 18);
    step(0, 0, 0, 0, 39, 16);

    // R6 then R7
    step(1, 0, 1, 0, 36, 16);
    step(0, 0, 0, 1, 36, 16);
    step(0, 0, 0, 1, 36, 16);
    step(0, 0, 0, 0, 36, 16);

    // long run to wrap the base several times
    step(1, 12, 2, 0, 32, 16);
    for (int i = 0; i < 16; i++) step(0, 0, 0, 1, 32 + i % N, 16 + i % N);

    for (int i = 0; i < 600; i++)
      step(($urandom % 16) == 0, $urandom % 6, $urandom % 5, $urandom % 2,
           $urandom % 128, $urandom % 64);

    done = 1;
    summary();
    $finish;
  end
endmodule